// File: doc/BRIEF.md
# Transmitter Power-Window Sequencer

This block frames the transmitter-power window around a single outgoing frame on a serial radio link. A frame request raises the power enable at once. A programmable lead interval gives the radio time to settle. The block then raises a data-release output, which tells the serializer to start shifting bits. When the serializer signals that the last CRC bit has gone out, the block keeps power applied for a programmable trailing interval. Filler bits are still shifted out during that interval. Power drops the moment the interval expires.

Both intervals are set by 3-bit fields and counted in coarse ticks. A tick is `TICK_BASE` input clocks (40 by default) when the clock-range select is low, and twice that when it is high. At a 20 MHz input clock with the select low, one tick is 2 µs. The fields and the select are captured when a frame is accepted, so software can change them for the next frame without disturbing the current one.

Top module: `txpw_window_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `pwr_en`, `data_go` and `busy` are all 0.
- R2: A `frame_req` sampled high while `busy` is 0 makes `pwr_en` and `busy` high on the next cycle, with `data_go` still 0.
- R3: `data_go` rises exactly N×T+1 clock cycles after `pwr_en` rises, where N is the value of `lead_cfg` (0 to 7) and T is the tick length. With N=0, release comes on the cycle after power-on.
- R4: The tick length T is `TICK_BASE` (40) clocks when `tick_sel` is 0, and 2×`TICK_BASE` (80) clocks when `tick_sel` is 1.
- R5: Once `data_go` rises, it stays high without a gap until `pwr_en` falls. `data_go` is never high while `pwr_en` is low.
- R6: `pwr_en` falls exactly M×T+1 clock cycles after the clock edge that samples the first `last_bit` seen while `data_go` is high, where M is the value of `trail_cfg`. `data_go` and `busy` fall on the same edge.
- R7: `lead_cfg`, `trail_cfg` and `tick_sel` are sampled only on the edge that accepts a frame. Changing them later has no effect on that frame's timing.
- R8: A `frame_req` sampled while `busy` is high is ignored. It produces no additional power window, and it does not alter the current window's timing.
- R9: A `last_bit` sampled before `data_go` has risen, or during the trailing interval, is ignored and does not shift any output edge.
- R10: `busy` is high from the cycle power is applied until the cycle `pwr_en` falls, and it equals `pwr_en` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_req | input | 1 | Request to open a power window for one frame |
| last_bit | input | 1 | Strobe from the serializer: final CRC bit has been sent |
| lead_cfg | input | FIELD_W | Lead interval in ticks |
| trail_cfg | input | FIELD_W | Trailing interval in ticks |
| tick_sel | input | 1 | Clock-range select; 1 doubles the tick length |
| pwr_en | output | 1 | Transmitter power enable |
| data_go | output | 1 | Data release to the serializer (held through the trailing filler) |
| busy | output | 1 | Power window in progress |

## Verification
Every cycle, the assertions enforce the following:
- the ordering of the outputs (data release only inside the power window, `busy` tied to `pwr_en`, all outputs dropping together);
- the exact lead and trail lengths, using cycle counters that are referenced to the configuration captured at frame acceptance.

Some properties cannot be judged from a single cycle. These need the bench's scenarios:
- that a configuration change after acceptance has no effect on the frame;
- that stray requests and stray last-bit strobes do not add or shift edges;
- that no spurious window opens after a frame.

The bench covers these with a scoreboard that predicts every output edge.

// File: rtl/txpw_pkg.sv
package txpw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SEND  = 2'd2,
    ST_TRAIL = 2'd3
  } txpw_state_e;

  // Clock cycles covered by a field value counted in ticks.
  function automatic int span_cycles(input int field, input logic long_tick, input int base);
    return field * (long_tick ? 2 * base : base);
  endfunction

endpackage

// File: rtl/txpw_cfg_latch.sv
module txpw_cfg_latch #(
  parameter int FIELD_W   = 3,
  parameter int TICK_BASE = 40,
  parameter int CNT_W     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [FIELD_W-1:0] lead_f,
  input  logic [FIELD_W-1:0] trail_f,
  input  logic               sel,
  output logic [CNT_W-1:0]   lead_span,
  output logic [CNT_W-1:0]   trail_span
);
  import txpw_pkg::*;

  logic [FIELD_W-1:0] trail_q;
  logic               sel_q;

  // Lead span is consumed on the capture edge itself, so it comes from live inputs.
  assign lead_span  = CNT_W'(span_cycles(int'(lead_f), sel, TICK_BASE));
  // Trail span is consumed much later, so it comes from the captured copy.
  assign trail_span = CNT_W'(span_cycles(int'(trail_q), sel_q, TICK_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      trail_q <= '0;
      sel_q   <= 1'b0;
    end else if (capture) begin
      trail_q <= trail_f;
      sel_q   <= sel;
    end
  end

endmodule

// File: rtl/txpw_span_timer.sv
module txpw_span_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/txpw_window_seq.sv
module txpw_window_seq #(
  parameter int FIELD_W   = 3,
  parameter int TICK_BASE = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_req,
  input  logic               last_bit,
  input  logic [FIELD_W-1:0] lead_cfg,
  input  logic [FIELD_W-1:0] trail_cfg,
  input  logic               tick_sel,
  output logic               pwr_en,
  output logic               data_go,
  output logic               busy
);
  import txpw_pkg::*;

  localparam int TICK_LONG = 2 * TICK_BASE;
  localparam int SPAN_MAX  = ((1 << FIELD_W) - 1) * TICK_LONG;
  localparam int CNT_W     = $clog2(SPAN_MAX + 1);

  txpw_state_e      state_q;
  logic             start;
  logic             tail_go;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] lead_span;
  logic [CNT_W-1:0] trail_span;
  logic [CNT_W-1:0] tmr_val;

  assign start    = frame_req && (state_q == ST_IDLE);
  assign tail_go  = last_bit && (state_q == ST_SEND);
  assign tmr_load = start || tail_go;
  assign tmr_val  = start ? lead_span : trail_span;

  txpw_cfg_latch #(
    .FIELD_W  (FIELD_W),
    .TICK_BASE(TICK_BASE),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .capture   (start),
    .lead_f    (lead_cfg),
    .trail_f   (trail_cfg),
    .sel       (tick_sel),
    .lead_span (lead_span),
    .trail_span(trail_span)
  );

  txpw_span_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pwr_en  <= 1'b0;
      data_go <= 1'b0;
      busy    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_LEAD;
            pwr_en  <= 1'b1;
            busy    <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tmr_zero) begin
            state_q <= ST_SEND;
            data_go <= 1'b1;
          end
        end
        ST_SEND: begin
          if (tail_go) begin
            state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tmr_zero) begin
            state_q <= ST_IDLE;
            pwr_en  <= 1'b0;
            data_go <= 1'b0;
            busy    <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txpw_window_chk.sv
module txpw_window_chk #(
  parameter int FIELD_W   = 3,
  parameter int TICK_BASE = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_req,
  input logic               last_bit,
  input logic [FIELD_W-1:0] lead_cfg,
  input logic [FIELD_W-1:0] trail_cfg,
  input logic               tick_sel,
  input logic               pwr_en,
  input logic               data_go,
  input logic               busy
);
  localparam int SPAN_MAX = ((1 << FIELD_W) - 1) * 2 * TICK_BASE;
  localparam int W        = $clog2(SPAN_MAX + 2) + 1;

  logic [FIELD_W-1:0] lead_q, trail_q;
  logic               sel_q;
  logic               trl_q;
  logic [W-1:0]       lcnt_q, tcnt_q;
  logic [W-1:0]       lead_exp, trail_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q  <= '0;
      trail_q <= '0;
      sel_q   <= 1'b0;
      trl_q   <= 1'b0;
      lcnt_q  <= '0;
      tcnt_q  <= '0;
    end else begin
      if (frame_req && !busy) begin
        lead_q  <= lead_cfg;
        trail_q <= trail_cfg;
        sel_q   <= tick_sel;
      end
      if (!pwr_en)       lcnt_q <= '0;
      else if (!data_go) lcnt_q <= lcnt_q + 1'b1;
      if (!pwr_en) begin
        trl_q  <= 1'b0;
        tcnt_q <= '0;
      end else if (data_go && last_bit && !trl_q) begin
        trl_q  <= 1'b1;
        tcnt_q <= '0;
      end else if (trl_q) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign lead_exp  = W'(int'(lead_q)  * (sel_q ? 2 * TICK_BASE : TICK_BASE) + 1);
  assign trail_exp = W'(int'(trail_q) * (sel_q ? 2 * TICK_BASE : TICK_BASE) + 1);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pwr_en && !data_go && !busy));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_req && !busy) |=> (pwr_en && busy && !data_go));

  // R3 and R4: lead length in the captured tick size
  p_lead_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_go) |-> (lcnt_q == lead_exp));

  p_data_inside_r5: assert property (@(posedge clk) disable iff (rst)
    data_go |-> pwr_en);

  p_trail_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> (tcnt_q == trail_exp));

  p_drop_together_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> (!data_go && !busy));

  p_open_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(!busy));

  p_busy_tracks_r10: assert property (@(posedge clk) disable iff (rst)
    busy == pwr_en);

endmodule

bind txpw_window_seq txpw_window_chk #(
  .FIELD_W  (FIELD_W),
  .TICK_BASE(TICK_BASE)
) u_chk (.*);

// File: tb/sim_txpw_window_seq.sv
module sim_txpw_window_seq;
  localparam int FW = 3;
  localparam int TB = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_req = 1'b0;
  logic          last_bit = 1'b0;
  logic [FW-1:0] lead_cfg = '0;
  logic [FW-1:0] trail_cfg = '0;
  logic          tick_sel = 1'b0;
  logic          pwr_en, data_go, busy;

  txpw_window_seq #(.FIELD_W(FW), .TICK_BASE(TB)) u0 (
    .clk(clk), .rst(rst), .frame_req(frame_req), .last_bit(last_bit),
    .lead_cfg(lead_cfg), .trail_cfg(trail_cfg), .tick_sel(tick_sel),
    .pwr_en(pwr_en), .data_go(data_go), .busy(busy)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_req[$];

  // Event kinds: 1 power up, 2 data release, 3 power down, 4 data drop alone
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_evt(input int kind, input int at, input string req);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_req.push_back(req);
  endtask

  function automatic int tick(input bit sel);
    return sel ? 2 * TB : TB;
  endfunction

  task automatic take(input int kind);
    int    k;
    int    c;
    string r;
    if (exp_kind.size() == 0) begin
      chk(1'b0, "R8 unexpected edge", kind, 0);
    end else begin
      k = exp_kind.pop_front();
      c = exp_cyc.pop_front();
      r = exp_req.pop_front();
      chk(k == kind, {r, " edge kind"}, kind, k);
      chk(c == cyc,  {r, " edge cycle"}, cyc, c);
      if (kind == 1 || kind == 3) begin
        chk(busy == pwr_en, "R10 busy follows window", int'(busy), int'(pwr_en));
        chk(!data_go, "R5 data low at window edge", int'(data_go), 0);
      end
    end
  endtask

  // Monitor
  bit p_pwr = 1'b0;
  bit p_data = 1'b0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pwr_en && !p_pwr) take(1);
      if (data_go && !p_data) take(2);
      if (!pwr_en && p_pwr) take(3);
      else if (!data_go && p_data) take(4);
    end
    p_pwr  = pwr_en;
    p_data = data_go;
  end

  // Driver
  task automatic frame(input int ld, input int tr, input bit sel, input int gap,
                       input bit poke_req, input bit poke_last, input bit swap_cfg);
    int t0;
    @(negedge clk);
    lead_cfg  = FW'(ld);
    trail_cfg = FW'(tr);
    tick_sel  = sel;
    frame_req = 1'b1;
    t0 = cyc + 1;
    expect_evt(1, t0, "R2");
    expect_evt(2, t0 + ld * tick(sel) + 1, (sel ? "R4" : "R3"));
    @(negedge clk);
    frame_req = 1'b0;
    if (swap_cfg) begin   // R7: later changes must not matter
      lead_cfg  = ~FW'(ld);
      trail_cfg = ~FW'(tr);
      tick_sel  = ~sel;
    end
    if (poke_last && !data_go) begin  // R9: strobe before release
      last_bit = 1'b1;
      @(negedge clk);
      last_bit = 1'b0;
    end
    if (poke_req) begin               // R8: request while busy
      frame_req = 1'b1;
      @(negedge clk);
      frame_req = 1'b0;
    end
    while (!data_go) @(negedge clk);
    repeat (gap) @(negedge clk);
    last_bit = 1'b1;
    expect_evt(3, cyc + 2 + tr * tick(sel), "R6");
    if (poke_req) frame_req = 1'b1;
    @(negedge clk);
    last_bit  = 1'b0;
    frame_req = 1'b0;
    if (poke_last && tr > 0) begin    // R9: strobe during trailing interval
      @(negedge clk);
      last_bit = 1'b1;
      @(negedge clk);
      last_bit = 1'b0;
    end
    while (pwr_en) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pwr_en && !data_go && !busy, "R1 outputs low in reset",
        int'({pwr_en, data_go, busy}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pwr_en && !data_go && !busy, "R1 outputs low after reset",
        int'({pwr_en, data_go, busy}), 0);
    frame(0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0);   // R3/R6 zero fields
    frame(7, 7, 1'b0, 10, 1'b0, 1'b0, 1'b0);
    frame(3, 2, 1'b1, 4, 1'b0, 1'b0, 1'b0);   // R4 long tick
    frame(7, 7, 1'b1, 2, 1'b1, 1'b1, 1'b1);   // R7 R8 R9
    frame(1, 5, 1'b0, 0, 1'b1, 1'b1, 1'b1);
    frame(2, 0, 1'b0, 3, 1'b0, 1'b1, 1'b0);
    chk(exp_kind.size() == 0, "R8 all predicted edges seen", exp_kind.size(), 0);
    chk(!pwr_en && !busy, "R10 idle at end", int'({pwr_en, busy}), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog R1-R10 run hung", cyc, 0);
    finish_run();
  end

endmodule